// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that gives a bus master access to an on-chip byte-wide random-access array. It oversamples SCL and SDA with the system clock and detects START, repeated START and STOP. It decodes a 7-bit target address, made of the fixed type code 1010b and three strap pins, and then serves any number of sequential byte writes or reads through one internal auto-incrementing pointer.

Writes have no page buffer and no write delay. Each received byte goes into the array as soon as its eighth bit has been sampled, before the acknowledge is driven. The pointer is shared by writes and current-address reads and keeps its value across transactions. A random read is a write-type header that loads the pointer, followed by a repeated START with the read bit set. A write-protect input makes the target refuse data bytes without changing the array or the pointer. The array is `2**ADDR_W` bytes. The default `ADDR_W = 11` keeps the default build small. `ADDR_W = 13` gives the full 8K map, which wraps from 1FFFh.

Top module: `i2c_mem_target`

## Requirements
- R1: The first byte after START is acknowledged only if bits 7..4 equal 1010b and bits 3..1 equal `sel_i`. Bit 0 set to 1 selects a read and set to 0 selects a write. On a mismatch the target leaves SDA released and ignores the bus until the next START or STOP.
- R2: In a write header, two address bytes follow, high byte first, and each is acknowledged. The low `ADDR_W` bits of {high, low} are loaded into the pointer.
- R3: Each data byte received MSB first is stored at the pointer when its eighth bit is sampled and then acknowledged. The pointer then advances by one, so consecutive bytes land at consecutive addresses.
- R4: The pointer wraps from `2**ADDR_W-1` to 0 on both writes and reads.
- R5: A read starts at the current pointer. A random read is a write header that loads the pointer, followed by a repeated START with the read bit set.
- R6: In a read the target shifts out a byte MSB first and then samples the master's acknowledge bit. A low bit (ACK) makes the target send the next sequential byte. A high bit (NACK) makes it release SDA and end the read.
- R7: A START or STOP that arrives before the eighth bit of a data byte discards that byte. Neither the array nor the pointer changes.
- R8: While `wp_i` is high, the target still acknowledges the target address and the address bytes but does not acknowledge data bytes, and neither the array nor the pointer changes.
- R9: The pointer keeps its value across STOP and later transactions. Reset clears it to 0 and releases SDA.
- R10: `sda_oe_o` changes only while the synchronised SCL is low, except when a START or STOP forces a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| sel_i | input | 3 | Strap value matched against address bits 3..1 |
| wp_i | input | 1 | High blocks all array writes |

## Verification
The assertions assume that SCL and SDA change only at intervals several system clocks long, so that each bus level is seen by the synchroniser for more than one cycle. They also assume that the master changes SDA only while SCL is low, except to form START and STOP. The bench holds every bus phase for eight system clocks and changes its data level only in the low phase of SCL. It changes `wp_i` and `sel_i` only between transactions and never issues START or STOP while the target is driving SDA.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_ACKT, ST_RDAT, ST_ACKR
  } st_e;
  localparam logic [3:0] TYPE_ID = 4'b1010;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_p  <= scl_ff[SYNC_N-1];
      sda_p  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_N-1];
  assign sda_o      = sda_ff[SYNC_N-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [2:0]    sel_i,
  input  logic          wp_i,
  input  logic [7:0]    rdata_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] ptr_o,
  output logic          sda_oe_o,
  output st_e           st_o
);
  st_e        st, nxt;
  logic [2:0] bcnt;
  logic [7:0] sh, hi;
  logic       do_ack, slot, m_ack;
  logic [7:0] rx_byte;
  logic [15:0] full_addr;
  logic       dev_hit;

  assign rx_byte   = {sh[6:0], sda_i};
  assign full_addr = {hi, rx_byte};
  assign dev_hit   = (rx_byte[7:4] == TYPE_ID) && (rx_byte[3:1] == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      nxt      <= ST_IDLE;
      bcnt     <= '0;
      sh       <= '0;
      hi       <= '0;
      do_ack   <= 1'b0;
      slot     <= 1'b0;
      m_ack    <= 1'b0;
      ptr_o    <= '0;
      waddr_o  <= '0;
      wdata_o  <= '0;
      we_o     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st       <= ST_DEV;
        bcnt     <= '0;
        slot     <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: if (scl_rise_i) begin
            sh   <= rx_byte;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st     <= ST_ACKT;
              slot   <= 1'b0;
              do_ack <= 1'b1;
              unique case (st)
                ST_DEV: begin
                  nxt <= rx_byte[0] ? ST_RDAT : ST_AHI;
                  if (!dev_hit) st <= ST_IDLE;
                end
                ST_AHI: begin
                  hi  <= rx_byte;
                  nxt <= ST_ALO;
                end
                ST_ALO: begin
                  ptr_o <= full_addr[AW-1:0];
                  nxt   <= ST_WDAT;
                end
                default: begin
                  nxt <= ST_WDAT;
                  if (wp_i) do_ack <= 1'b0;
                  else begin
                    we_o    <= 1'b1;
                    waddr_o <= ptr_o;
                    wdata_o <= rx_byte;
                    ptr_o   <= ptr_o + 1'b1;
                  end
                end
              endcase
            end
          end
          ST_ACKT: if (scl_fall_i) begin
            if (!slot) begin
              sda_oe_o <= do_ack;
              slot     <= 1'b1;
            end else begin
              slot     <= 1'b0;
              bcnt     <= '0;
              st       <= nxt;
              sda_oe_o <= 1'b0;
              if (nxt == ST_RDAT) begin
                sh       <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
                ptr_o    <= ptr_o + 1'b1;
              end
            end
          end
          ST_RDAT: if (scl_fall_i) begin
            if (bcnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              st       <= ST_ACKR;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_oe_o <= ~sh[6];
              bcnt     <= bcnt + 3'd1;
            end
          end
          ST_ACKR: begin
            if (scl_rise_i) m_ack <= ~sda_i;
            if (scl_fall_i) begin
              if (m_ack) begin
                sh       <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
                ptr_o    <= ptr_o + 1'b1;
                bcnt     <= '0;
                st       <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign st_o = st;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] sel_i,
  input  logic       wp_i
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic              mem_we;
  logic [ADDR_W-1:0] waddr, ptr;
  logic [7:0]        wdata, rdata;
  st_e               st;

  i2c_bus_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  i2c_mem_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_s), .stop_i(stop_s), .sda_i(sda_s),
    .sel_i, .wp_i, .rdata_i(rdata),
    .we_o(mem_we), .waddr_o(waddr), .wdata_o(wdata), .ptr_o(ptr),
    .sda_oe_o, .st_o(st)
  );

  i2c_mem_array #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata)
  );
endmodule

// File: rtl/i2c_mem_checker.sv
module i2c_mem_checker
  import i2c_mem_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sda_oe_i,
  input logic          scl_s_i,
  input logic          start_s_i,
  input logic          stop_s_i,
  input st_e           st_i,
  input logic          mem_we_i,
  input logic [AW-1:0] waddr_i,
  input logic [AW-1:0] ptr_i,
  input logic          wp_i
);
  localparam logic [AW-1:0] ONE = 1;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> (!scl_s_i || $past(start_s_i || stop_s_i))); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_i); // R1

  AST_WP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !$past(wp_i)); // R8

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (ptr_i == waddr_i + ONE)); // R3

  AST_PTR_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && $past(st_i == ST_IDLE)) |-> $stable(ptr_i)); // R9
endmodule

bind i2c_mem_target i2c_mem_checker #(.AW(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .scl_s_i(scl_s),
  .start_s_i(start_s), .stop_s_i(stop_s), .st_i(st), .mem_we_i(mem_we),
  .waddr_i(waddr), .ptr_i(ptr), .wp_i(wp_i)
);

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
  localparam int AW = 11;
  localparam int Q  = 8;
  localparam logic [2:0] SEL = 3'b101;
  localparam int NV = 6;
  // {address, data}
  localparam logic [18:0] VEC [NV] = '{
    {11'h001, 8'h5E}, {11'h2AA, 8'h81}, {11'h555, 8'h7F},
    {11'h3F0, 8'h00}, {11'h123, 8'hFF}, {11'h7FE, 8'hC9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic [2:0] sel = SEL;
  logic sda_oe;
  logic sda_bus;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .sel_i(sel), .wp_i(wp)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic set_ptr(logic [AW-1:0] a, output logic ok);
    logic a1, a2, a3;
    bus_start();
    put_byte({4'hA, SEL, 1'b0}, a1);
    put_byte({5'b0, a[10:8]}, a2);
    put_byte(a[7:0], a3);
    ok = a1 & a2 & a3;
  endtask

  task automatic wr1(logic [AW-1:0] a, logic [7:0] d, output logic ack);
    logic ok;
    set_ptr(a, ok);
    put_byte(d, ack);
    bus_stop();
  endtask

  task automatic rd_start(output logic ack);
    bus_start();
    put_byte({4'hA, SEL, 1'b1}, ack);
  endtask

  task automatic rd1(logic [AW-1:0] a, output logic [7:0] d);
    logic ok, ack;
    set_ptr(a, ok);
    rd_start(ack);
    get_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic ack, ok;
    logic [7:0] d;
    tick(5);
    chk("R9 reset oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);

    // vector table: random write then random read
    for (int v = 0; v < NV; v++) begin
      wr1(VEC[v][18:8], VEC[v][7:0], ack);
      chk("R3 data ack", int'(ack), 1);
      rd1(VEC[v][18:8], d);
      chk("R5 random read", int'(d), int'(VEC[v][7:0]));
    end

    // wrong type code and wrong strap
    bus_start();
    put_byte({4'hB, SEL, 1'b0}, ack);
    chk("R1 type nack", int'(ack), 0);
    put_byte(8'h00, ack);
    chk("R1 ignored after mismatch", int'(ack), 0);
    bus_stop();
    bus_start();
    put_byte({4'hA, 3'b001, 1'b0}, ack);
    chk("R1 sel nack", int'(ack), 0);
    bus_stop();

    // sequential write of 5 bytes, address acks
    set_ptr(11'h100, ok);
    chk("R2 address acks", int'(ok), 1);
    for (int i = 0; i < 5; i++) put_byte(8'h10 + 8'(i), ack);
    bus_stop();
    set_ptr(11'h100, ok);
    rd_start(ack);
    chk("R1 read dev ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      get_byte(d, i != 3);
      chk("R6 sequential read", int'(d), 16 + i);
    end
    tick(2);
    chk("R6 released after nack", int'(sda_oe), 0);
    bus_stop();
    // pointer persists across STOP: current-address read
    rd_start(ack);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R9 pointer persists", int'(d), 8'h14);

    // wrap
    set_ptr(11'h7FF, ok);
    put_byte(8'h11, ack);
    put_byte(8'h22, ack);
    bus_stop();
    set_ptr(11'h7FF, ok);
    rd_start(ack);
    get_byte(d, 1'b1);
    chk("R4 last address", int'(d), 8'h11);
    get_byte(d, 1'b0);
    chk("R4 wrapped to zero", int'(d), 8'h22);
    bus_stop();

    // partial byte aborted by STOP
    wr1(11'h050, 8'h3C, ack);
    set_ptr(11'h050, ok);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    rd1(11'h050, d);
    chk("R7 stop abort", int'(d), 8'h3C);
    // partial byte aborted by repeated START
    wr1(11'h051, 8'hC3, ack);
    set_ptr(11'h051, ok);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    rd_start(ack);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R7 restart abort", int'(d), 8'hC3);

    // write protect
    wr1(11'h060, 8'h5A, ack);
    wp = 1'b1;
    set_ptr(11'h060, ok);
    chk("R8 address acked", int'(ok), 1);
    put_byte(8'h99, ack);
    chk("R8 data nack", int'(ack), 0);
    bus_stop();
    wp = 1'b0;
    rd_start(ack);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R8 no write no step", int'(d), 8'h5A);

    // reset clears pointer
    rst_n = 1'b0;
    tick(4);
    chk("R9 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(4);
    rd_start(ack);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R9 pointer reset", int'(d), 8'h22);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule